// File: doc/BRIEF.md
# Linked-Read / Conditional-Write Reservation Monitor

This block sits in front of a small shared word-addressed memory and serves two requesters. Besides plain reads and writes it offers a linked read and a conditional write. A linked read returns the stored word and records a per-requester reservation on that address. A later conditional write from the same requester stores its data only if that reservation is still intact, and it answers 1 on success or 0 on failure. The software above it loops on the pair until it sees 1. The result is an atomic read-modify-write with no locked bus cycle.

Any write that lands on a reserved address cancels every reservation held on it. That write may be a plain store or a successful conditional write, and it may come from either requester. A round-robin arbiter admits one access per cycle. A requester that is held sees its ready low and keeps its request up. Every granted access returns exactly one response, one cycle after the grant. Reset is asserted asynchronously and released through a two-stage synchroniser. The memory array itself is not cleared by reset.

Top module: `llsc_monitor`

## Requirements
- R1: After reset is released, no response is pending, no ready is high while no request is valid, and no requester holds a reservation: a conditional write issued before any linked read fails with 0 and leaves memory unchanged.
- R2: A granted plain read (op code 2'b00) returns the addressed word on that requester's rsp_data with rsp_valid high, exactly one cycle after the ready cycle.
- R3: A granted plain write (op code 2'b01) stores wdata at the address and responds with data 0 one cycle later.
- R4: A granted linked read (op code 2'b10) returns the addressed word one cycle later and records a reservation for the issuer on that address.
- R5: A granted conditional write (op code 2'b11) whose issuer holds a valid reservation on the same address stores its data, responds 1, and clears the issuer's reservation, so that an immediate repeat fails.
- R6: A failing conditional write responds 0 and leaves memory unchanged.
- R7: A plain write or a successful conditional write to an address cancels every reservation on that address, including the writer's own. Writes to other addresses leave the reservations in place.
- R8: A conditional write to an address other than the reserved one fails and also clears the issuer's reservation.
- R9: A new linked read by a requester replaces that requester's earlier reservation address.
- R10: When both requesters are valid, exactly one ready is high. Priority alternates: the requester not granted last wins, and priority starts with requester 0 after reset.
- R11: When exactly one requester is valid, it receives ready in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_op | input | 2*NREQ | Operation per requester: 00 read, 01 write, 10 linked read, 11 conditional write |
| req_addr | input | NREQ*AW | Word address per requester |
| req_wdata | input | NREQ*DW | Write data per requester |
| req_ready | output | NREQ | Grant; the request is taken in a cycle where valid and ready are both high |
| rsp_valid | output | NREQ | Response valid, one cycle after the grant |
| rsp_data | output | NREQ*DW | Read word, conditional result (1/0), or 0 for a plain write |

## Verification
A reservation bit stuck high shows as a conditional write that answers 1 after another requester has overwritten the word. A bit lost early shows as a 0 where 1 was due. Either error is visible on rsp_data one cycle after the conditional write is granted. It is also visible on the next plain read of that address, because a wrong outcome also changes the stored word. A wrong arbitration pointer shows in the same cycle as a ready on the wrong lane while both requesters are valid. A wrong address compare gets through only when the reserved and written addresses differ. The directed sequences therefore place writes both on the reserved address and next to it.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_rst_sync.sv
module llsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/llsc_rr_arb.sv
module llsc_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, ptr_d;
  logic [PW-1:0] win;
  logic          found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        win      = PW'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (found) begin
      if (win == PW'(N - 1)) ptr_d = '0;
      else                   ptr_d = PW'(win + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          own_link,
  input  logic          own_cond,
  input  logic [AW-1:0] op_addr,
  input  logic          wr_en,
  output logic          resv_valid,
  output logic [AW-1:0] resv_addr
);
  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (own_link) begin
      valid_d = 1'b1;
      addr_d  = op_addr;
      addr_en = 1'b1;
    end else if (own_cond) begin
      valid_d = 1'b0;
    end else if (wr_en && valid_q && (op_addr == addr_q)) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign resv_valid = valid_q;
  assign resv_addr  = addr_q;
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en) cell_q[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= cell_q[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NREQ = 2,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  input  logic [2*NREQ-1:0]  req_op,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ*DW-1:0] req_wdata,
  output logic [NREQ-1:0]    req_ready,
  output logic [NREQ-1:0]    rsp_valid,
  output logic [NREQ*DW-1:0] rsp_data
);
  logic              rst_sync_n;
  logic [NREQ-1:0]   req_eff;
  logic [NREQ-1:0]   gnt;
  logic              any_gnt;
  llsc_op_e          sel_op;
  logic [AW-1:0]     sel_addr;
  logic [DW-1:0]     sel_wdata;
  logic [NREQ-1:0]   resv_valid;
  logic [AW-1:0]     resv_addr [NREQ];
  logic              sel_resv_valid;
  logic [AW-1:0]     sel_resv_addr;
  logic              cond_ok;
  logic              mem_wr;
  logic              mem_rd;
  logic [DW-1:0]     mem_rdata;

  logic [NREQ-1:0]   rsp_valid_q, rsp_valid_d;
  llsc_op_e          rsp_kind_q, rsp_kind_d;
  logic              rsp_flag_q, rsp_flag_d;
  logic              rsp_meta_en;
  logic [DW-1:0]     payload;

  llsc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign req_eff = req_valid & {NREQ{rst_sync_n}};

  llsc_rr_arb #(.N(NREQ)) u_arb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (req_eff),
    .gnt   (gnt)
  );

  assign req_ready = gnt;
  assign any_gnt   = |gnt;

  // Select the granted lane's request and reservation
  always_comb begin
    sel_op         = OP_READ;
    sel_addr       = '0;
    sel_wdata      = '0;
    sel_resv_valid = 1'b0;
    sel_resv_addr  = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (gnt[i]) begin
        sel_op         = llsc_op_e'(req_op[2*i +: 2]);
        sel_addr       = req_addr[i*AW +: AW];
        sel_wdata      = req_wdata[i*DW +: DW];
        sel_resv_valid = resv_valid[i];
        sel_resv_addr  = resv_addr[i];
      end
    end
  end

  assign cond_ok = any_gnt && (sel_op == OP_COND) && sel_resv_valid &&
                   (sel_resv_addr == sel_addr);
  assign mem_wr  = any_gnt && ((sel_op == OP_WRITE) || cond_ok);
  assign mem_rd  = any_gnt && ((sel_op == OP_READ) || (sel_op == OP_LINK));

  genvar g;
  generate
    for (g = 0; g < NREQ; g++) begin : g_slot
      llsc_resv_slot #(.AW(AW)) u_slot (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .own_link   (gnt[g] && (sel_op == OP_LINK)),
        .own_cond   (gnt[g] && (sel_op == OP_COND)),
        .op_addr    (sel_addr),
        .wr_en      (mem_wr),
        .resv_valid (resv_valid[g]),
        .resv_addr  (resv_addr[g])
      );
    end
  endgenerate

  llsc_word_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (mem_wr),
    .rd_en (mem_rd),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (mem_rdata)
  );

  // Response next state
  always_comb begin
    rsp_valid_d = gnt;
    rsp_meta_en = any_gnt;
    rsp_kind_d  = sel_op;
    rsp_flag_d  = cond_ok;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rsp_valid_q <= '0;
    else             rsp_valid_q <= rsp_valid_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_kind_q <= OP_READ;
      rsp_flag_q <= 1'b0;
    end else if (rsp_meta_en) begin
      rsp_kind_q <= rsp_kind_d;
      rsp_flag_q <= rsp_flag_d;
    end
  end

  always_comb begin
    case (rsp_kind_q)
      OP_READ, OP_LINK: payload = mem_rdata;
      OP_COND:          payload = DW'(rsp_flag_q);
      default:          payload = '0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      rsp_data[i*DW +: DW] = rsp_valid_q[i] ? payload : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int N  = 2,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req_valid,
  input logic [2*N-1:0]  req_op,
  input logic [N-1:0]    req_ready,
  input logic [N-1:0]    rsp_valid,
  input logic [N*DW-1:0] rsp_data
);
  AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R10

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0); // R10

  AST_LONE_REQ_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req_valid) == 1) |-> (req_ready == req_valid)); // R11

  AST_PRIORITY_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready[0] ##1 req_valid[1] |-> req_ready[1]); // R10

  AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> (rsp_valid == $past(req_ready))); // R2

  AST_NO_RSP_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready == '0) |=> (rsp_valid == '0)); // R2

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_lane
      AST_COND_RESULT_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready[i] && (req_op[2*i +: 2] == 2'b11)) |=>
          (rsp_data[i*DW +: DW] <= DW'(1))); // R5

      AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready[i] && (req_op[2*i +: 2] == 2'b01)) |=>
          (rsp_data[i*DW +: DW] == '0)); // R3
    end
  endgenerate
endmodule

bind llsc_monitor llsc_monitor_chk #(.N(NREQ), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;
  localparam int NREQ = 2;
  localparam int AW   = 4;
  localparam int DW   = 32;

  logic               clk;
  logic               rst_n;
  logic [NREQ-1:0]    req_valid;
  logic [2*NREQ-1:0]  req_op;
  logic [NREQ*AW-1:0] req_addr;
  logic [NREQ*DW-1:0] req_wdata;
  logic [NREQ-1:0]    req_ready;
  logic [NREQ-1:0]    rsp_valid;
  logic [NREQ*DW-1:0] rsp_data;

  llsc_monitor #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut_i (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_ready (req_ready),
    .rsp_valid (rsp_valid), .rsp_data (rsp_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Bench model
  logic [DW-1:0] m_mem [16];
  bit            m_rv [2];
  logic [AW-1:0] m_ra [2];
  int            m_prio;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [1:0] op, input bit ok);
    case (op)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return ok ? "R5" : "R6";
    endcase
  endfunction

  // One cycle: drive, check grant, update model, check response
  task automatic cyc(input logic [1:0] v,
                     input logic [1:0] o0, input logic [3:0] a0, input logic [31:0] d0,
                     input logic [1:0] o1, input logic [3:0] a1, input logic [31:0] d1,
                     input string tag);
    int g;
    bit any;
    logic [1:0] exp_rdy;
    logic [1:0] op;
    logic [3:0] a;
    logic [31:0] d, exp_d;
    bit ok;
    string t;
    req_valid = v;
    req_op    = {o1, o0};
    req_addr  = {a1, a0};
    req_wdata = {d1, d0};
    #1;
    any = |v;
    if (v == 2'b11) g = m_prio;
    else if (v[0])  g = 0;
    else            g = 1;
    exp_rdy = any ? (2'b01 << g) : 2'b00;
    chk(req_ready == exp_rdy, (v == 2'b11) ? "R10 ready" : "R11 ready",
        32'(req_ready), 32'(exp_rdy));
    exp_d = '0;
    ok = 1'b0;
    op = 2'b00;
    if (any) begin
      op = g ? o1 : o0;
      a  = g ? a1 : a0;
      d  = g ? d1 : d0;
      case (op)
        2'b00: exp_d = m_mem[a];
        2'b01: begin
          m_mem[a] = d;
          for (int k = 0; k < 2; k++) if (m_ra[k] == a) m_rv[k] = 1'b0;
        end
        2'b10: begin
          exp_d = m_mem[a];
          m_rv[g] = 1'b1;
          m_ra[g] = a;
        end
        default: begin
          ok = m_rv[g] && (m_ra[g] == a);
          m_rv[g] = 1'b0;
          if (ok) begin
            m_mem[a] = d;
            for (int k = 0; k < 2; k++) if (m_ra[k] == a) m_rv[k] = 1'b0;
          end
          exp_d = ok ? 32'd1 : 32'd0;
        end
      endcase
      m_prio = 1 - g;
    end
    @(posedge clk);
    @(negedge clk);
    t = (tag != "") ? tag : op_tag(op, ok);
    chk(rsp_valid == exp_rdy, {t, " rsp_valid"}, 32'(rsp_valid), 32'(exp_rdy));
    if (any) chk(rsp_data[g*DW +: DW] === exp_d, {t, " rsp_data"},
                 rsp_data[g*DW +: DW], exp_d);
    req_valid = '0;
  endtask

  task automatic r0(input logic [1:0] o, input logic [3:0] a, input logic [31:0] d,
                    input string tag);
    cyc(2'b01, o, a, d, 2'b00, 4'd0, 32'd0, tag);
  endtask

  task automatic r1(input logic [1:0] o, input logic [3:0] a, input logic [31:0] d,
                    input string tag);
    cyc(2'b10, 2'b00, 4'd0, 32'd0, o, a, d, tag);
  endtask

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, LK = 2'b10, CW = 2'b11;

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    for (int k = 0; k < 2; k++) begin m_rv[k] = 1'b0; m_ra[k] = '0; end
    m_prio = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle state after reset
    #1;
    chk(rsp_valid == '0, "R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
    chk(req_ready == '0, "R1 ready idle", 32'(req_ready), 32'd0);

    // Fill memory (R3)
    for (int k = 0; k < 16; k++) r0(WR, 4'(k), 32'h1000_0000 + 32'(k), "R3");

    // R1: conditional write before any linked read fails, no write
    r0(CW, 4'd2, 32'hDEAD_0002, "R1");
    r1(CW, 4'd2, 32'hDEAD_0102, "R1");
    r0(RD, 4'd2, 32'd0, "R1");

    // R5: success then repeat fails
    r0(LK, 4'd5, 32'd0, "R4");
    r0(CW, 4'd5, 32'hAAAA_0005, "R5");
    r0(RD, 4'd5, 32'd0, "R5");
    r0(CW, 4'd5, 32'hBBBB_0005, "R5");
    r0(RD, 4'd5, 32'd0, "R6");

    // R7: other requester writes reserved address
    r0(LK, 4'd6, 32'd0, "R4");
    r1(WR, 4'd6, 32'h1111_0006, "R3");
    r0(CW, 4'd6, 32'hCCCC_0006, "R7");
    r0(RD, 4'd6, 32'd0, "R7");
    // R7: write to a neighbouring address leaves reservation
    r0(LK, 4'd7, 32'd0, "R4");
    r1(WR, 4'd8, 32'h2222_0008, "R3");
    r0(CW, 4'd7, 32'hCCCC_0007, "R7");
    // R7: own plain write cancels own reservation
    r0(LK, 4'd9, 32'd0, "R4");
    r0(WR, 4'd9, 32'h3333_0009, "R3");
    r0(CW, 4'd9, 32'hCCCC_0009, "R7");
    // R7: successful conditional write cancels the other reservation
    r0(LK, 4'd3, 32'd0, "R4");
    r1(LK, 4'd3, 32'd0, "R4");
    r1(CW, 4'd3, 32'h4444_0003, "R7");
    r0(CW, 4'd3, 32'h5555_0003, "R7");
    r1(RD, 4'd3, 32'd0, "R7");

    // R8: mismatching address fails and clears
    r0(LK, 4'd4, 32'd0, "R4");
    r0(CW, 4'd10, 32'h6666_000A, "R8");
    r0(CW, 4'd4, 32'h6666_0004, "R8");
    r0(RD, 4'd10, 32'd0, "R8");

    // R9: newer linked read replaces address
    r1(LK, 4'd11, 32'd0, "R4");
    r1(LK, 4'd12, 32'd0, "R4");
    r1(CW, 4'd11, 32'h7777_000B, "R9");
    r1(LK, 4'd11, 32'd0, "R4");
    r1(LK, 4'd12, 32'd0, "R4");
    r1(CW, 4'd12, 32'h7777_000C, "R9");

    // R10: contention alternates
    for (int k = 0; k < 6; k++)
      cyc(2'b11, RD, 4'(k), 32'd0, RD, 4'(k + 1), 32'd0, "R10");
    cyc(2'b11, LK, 4'd13, 32'd0, WR, 4'd13, 32'h8888_000D, "R10");
    cyc(2'b11, CW, 4'd13, 32'h9999_000D, LK, 4'd13, 32'd0, "R10");

    // Random mix on a few addresses to force conflicts
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] v;
      v = 2'($urandom % 4);
      cyc(v, 2'($urandom % 4), 4'($urandom % 4), $urandom,
             2'($urandom % 4), 4'($urandom % 4), $urandom, "");
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule